// File: doc/BRIEF.md
# Telephone Keypad Tone-Pair Controller

This block watches a 4-by-4 telephone keypad and works out what a dual-tone generator placed after it should produce. Row and column lines are active-low levels. A pressed key pulls one row line and one column line low together. The block first brings every input into the clock domain through a two-flop synchroniser. It then classifies each group of lines as having none, exactly one, or several lines active, and drives registered control outputs.

The outputs are:
- a mute flag;
- an enable and a 2-bit index for the low-frequency (row) group;
- an enable and a 2-bit index for the high-frequency (column) group;
- an output-active flag, which picks between a mid-scale offset code (high) and a fully-off code (low);
- an oscillator run enable.

Two control inputs shape the decision. `single_ok` permits single-tone output when several keys are held. `tone_off_n` is active-low and silences the tone path completely. Mute is decided independently of both.

Top module: `dtmf_keysense`

## Requirements
- R1: `mute` is high whenever at least one row or column line is low (active), whatever the levels of `single_ok` and `tone_off_n`.
- R2: With all row and column lines high (idle), `mute`, `out_active`, `osc_run`, `lo_en` and `hi_en` are all low.
- R3: With `tone_off_n` high and exactly one row line and one column line low, `lo_en` and `hi_en` are both high. `lo_idx` equals the bit position of the low row line and `hi_idx` the bit position of the low column line (bit 0 maps to index 0).
- R4: With `tone_off_n` and `single_ok` both high: two or more rows with exactly one column gives `hi_en` high and `lo_en` low; exactly one row with two or more columns gives `lo_en` high and `hi_en` low.
- R5: With `single_ok` low, any pattern other than exactly one row and one column gives both enables low.
- R6: Two or more rows together with two or more columns, or activity in only one of the two groups, gives both enables low for either level of `single_ok`.
- R7: With `tone_off_n` low, `lo_en`, `hi_en`, `osc_run` and `out_active` are low while `mute` still follows the lines.
- R8: `osc_run` is high exactly when `lo_en` or `hi_en` is high.
- R9: `out_active` is high exactly when `mute` is high and `tone_off_n` is high.
- R10: `lo_idx` is 0 unless exactly one row is active, and `hi_idx` is 0 unless exactly one column is active.
- R11: After reset every output is low. A change on any input appears on the outputs at the third rising clock edge after it and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_n | input | 4 | Row lines, active-low |
| col_n | input | 4 | Column lines, active-low |
| single_ok | input | 1 | High permits single-tone output on multiple closures |
| tone_off_n | input | 1 | Low silences the tone path |
| mute | output | 1 | Any line active |
| lo_en | output | 1 | Low-group tone enable |
| lo_idx | output | 2 | Active row index |
| hi_en | output | 1 | High-group tone enable |
| hi_idx | output | 2 | Active column index |
| out_active | output | 1 | High selects the offset code, low selects fully off |
| osc_run | output | 1 | Oscillator run enable |

## Verification
The bench sweeps all 256 row/column patterns under all four combinations of the two control inputs and predicts each output by counting active lines.

It targets several corner cases, each of which a specific design error would break:
- Multi-key patterns where only one group has several lines: a design that inverted `single_ok` or swapped the groups would sound the wrong tone here.
- Patterns where lines are active in one group only: a decoder that treated "one row, no column" as valid would start the oscillator.
- Tone-disabled cases: a design that gated mute with `tone_off_n` would drop mute.
- Output timing: a dropped or extra synchroniser stage would shift the output edge, so the bench samples one edge early as well as at the expected edge.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_ONE  = 2'd1,
    GRP_MANY = 2'd2
  } grp_cnt_e;
endpackage

// File: rtl/dtmf_sync.sv
module dtmf_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dtmf_grp_decode.sv
module dtmf_grp_decode
  import dtmf_pkg::*;
#(
  parameter int WIDTH = 4,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] act,
  output grp_cnt_e         cls,
  output logic [IDX_W-1:0] idx
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] pos;

  always_comb begin
    cnt = '0;
    pos = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (act[i]) begin
        cnt = cnt + CNT_W'(1);
        pos = pos | IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (cnt == '0)              cls = GRP_NONE;
    else if (cnt == CNT_W'(1))  cls = GRP_ONE;
    else                        cls = GRP_MANY;
  end

  assign idx = (cls == GRP_ONE) ? pos : '0;
endmodule

// File: rtl/dtmf_keysense.sv
module dtmf_keysense
  import dtmf_pkg::*;
#(
  parameter int N_ROWS      = 4,
  parameter int N_COLS      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ROW_IDX_W  = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
  localparam int COL_IDX_W  = (N_COLS > 1) ? $clog2(N_COLS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_ROWS-1:0]    row_n,
  input  logic [N_COLS-1:0]    col_n,
  input  logic                 single_ok,
  input  logic                 tone_off_n,
  output logic                 mute,
  output logic                 lo_en,
  output logic [ROW_IDX_W-1:0] lo_idx,
  output logic                 hi_en,
  output logic [COL_IDX_W-1:0] hi_idx,
  output logic                 out_active,
  output logic                 osc_run
);
  logic [N_ROWS-1:0] row_s;
  logic [N_COLS-1:0] col_s;
  logic [1:0]        ctl_s;

  dtmf_sync #(.WIDTH(N_ROWS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_row_sync (
    .clk(clk), .rst(rst), .d(row_n), .q(row_s)
  );
  dtmf_sync #(.WIDTH(N_COLS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_col_sync (
    .clk(clk), .rst(rst), .d(col_n), .q(col_s)
  );
  dtmf_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_ctl_sync (
    .clk(clk), .rst(rst), .d({tone_off_n, single_ok}), .q(ctl_s)
  );

  grp_cnt_e              row_cls, col_cls;
  logic [ROW_IDX_W-1:0]  row_pos;
  logic [COL_IDX_W-1:0]  col_pos;

  dtmf_grp_decode #(.WIDTH(N_ROWS)) u_row_dec (
    .act(~row_s), .cls(row_cls), .idx(row_pos)
  );
  dtmf_grp_decode #(.WIDTH(N_COLS)) u_col_dec (
    .act(~col_s), .cls(col_cls), .idx(col_pos)
  );

  logic allow_single, tone_on;
  logic any_nx, lo_nx, hi_nx;

  assign allow_single = ctl_s[0];
  assign tone_on      = ctl_s[1];

  always_comb begin
    any_nx = (row_cls != GRP_NONE) || (col_cls != GRP_NONE);
    lo_nx  = 1'b0;
    hi_nx  = 1'b0;
    if (tone_on) begin
      if (row_cls == GRP_ONE && col_cls == GRP_ONE) begin
        lo_nx = 1'b1;
        hi_nx = 1'b1;
      end else if (allow_single) begin
        if (row_cls == GRP_MANY && col_cls == GRP_ONE) hi_nx = 1'b1;
        if (row_cls == GRP_ONE && col_cls == GRP_MANY) lo_nx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mute       <= 1'b0;
      lo_en      <= 1'b0;
      hi_en      <= 1'b0;
      lo_idx     <= '0;
      hi_idx     <= '0;
      out_active <= 1'b0;
      osc_run    <= 1'b0;
    end else begin
      mute       <= any_nx;
      lo_en      <= lo_nx;
      hi_en      <= hi_nx;
      lo_idx     <= row_pos;
      hi_idx     <= col_pos;
      out_active <= any_nx & tone_on;
      osc_run    <= lo_nx | hi_nx;
    end
  end
endmodule

// File: rtl/dtmf_keysense_chk.sv
module dtmf_keysense_chk (
  input logic clk,
  input logic rst,
  input logic mute,
  input logic lo_en,
  input logic hi_en,
  input logic out_active,
  input logic osc_run
);
  // R9: offset level only while a line is active
  a_r9_active_needs_mute: assert property (@(posedge clk) disable iff (rst)
    out_active |-> mute);
  // R8: oscillator never runs without a tone enabled
  a_r8_osc_needs_tone: assert property (@(posedge clk) disable iff (rst)
    osc_run |-> (lo_en || hi_en));
  // R3: any enabled tone implies mute and an active output stage
  a_r3_tone_needs_mute: assert property (@(posedge clk) disable iff (rst)
    (lo_en || hi_en) |-> (mute && out_active && osc_run));
  // R2: idle lines leave everything off
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !mute |-> (!osc_run && !out_active && !lo_en && !hi_en));
endmodule

bind dtmf_keysense dtmf_keysense_chk u_chk (
  .clk(clk), .rst(rst), .mute(mute), .lo_en(lo_en), .hi_en(hi_en),
  .out_active(out_active), .osc_run(osc_run)
);

// File: tb/sim_dtmf_keysense.sv
module sim_dtmf_keysense;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] row_n = 4'hF;
  logic [3:0] col_n = 4'hF;
  logic       single_ok = 1'b0;
  logic       tone_off_n = 1'b1;
  logic       mute, lo_en, hi_en, out_active, osc_run;
  logic [1:0] lo_idx, hi_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dtmf_keysense u0 (
    .clk(clk), .rst(rst), .row_n(row_n), .col_n(col_n),
    .single_ok(single_ok), .tone_off_n(tone_off_n),
    .mute(mute), .lo_en(lo_en), .lo_idx(lo_idx), .hi_en(hi_en),
    .hi_idx(hi_idx), .out_active(out_active), .osc_run(osc_run)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (row_n=%b col_n=%b so=%b to=%b)",
               tag, act, exp, row_n, col_n, single_ok, tone_off_n);
    end
  endtask

  function automatic logic [1:0] pos_of(input logic [3:0] a);
    logic [1:0] p = 2'd0;
    for (int i = 0; i < 4; i++) if (a[i]) p = 2'(i);
    return p;
  endfunction

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11 reset", {1'b0, mute, lo_en, hi_en, out_active, osc_run, lo_idx[0], hi_idx[0]}, 8'h00);
    rst = 1'b0;

    // R11: latency of three edges
    @(negedge clk);
    row_n = 4'b1011; col_n = 4'b1101; single_ok = 1'b0; tone_off_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R11 early", {7'd0, mute}, 8'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R11 on time", {5'd0, mute, lo_en, hi_en}, 8'h07);

    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 256; p++) begin
        logic [3:0] ra, ca;
        int rc, cc;
        logic e_mute, e_lo, e_hi, e_oa, e_osc;
        logic [1:0] e_li, e_hi_i;
        string tag;
        row_n = ~p[3:0];
        col_n = ~p[7:4];
        single_ok = c[0];
        tone_off_n = c[1];
        ra = p[3:0];
        ca = p[7:4];
        rc = $countones(ra);
        cc = $countones(ca);
        e_mute = (rc + cc) != 0;
        e_lo = 1'b0; e_hi = 1'b0;
        if (tone_off_n) begin
          if (rc == 1 && cc == 1) begin e_lo = 1'b1; e_hi = 1'b1; end
          else if (single_ok && rc >= 2 && cc == 1) e_hi = 1'b1;
          else if (single_ok && rc == 1 && cc >= 2) e_lo = 1'b1;
        end
        e_oa   = e_mute & tone_off_n;
        e_osc  = e_lo | e_hi;
        e_li   = (rc == 1) ? pos_of(ra) : 2'd0;
        e_hi_i = (cc == 1) ? pos_of(ca) : 2'd0;
        if (!tone_off_n) tag = "R7";
        else if (rc == 0 && cc == 0) tag = "R2";
        else if (rc == 1 && cc == 1) tag = "R3";
        else if ((rc >= 2 && cc >= 2) || rc == 0 || cc == 0) tag = "R6";
        else if (single_ok) tag = "R4";
        else tag = "R5";
        settle();
        chk({tag, " enables"}, {6'd0, lo_en, hi_en}, {6'd0, e_lo, e_hi});
        chk("R1 mute", {7'd0, mute}, {7'd0, e_mute});
        chk("R8 osc_run", {7'd0, osc_run}, {7'd0, e_osc});
        chk("R9 out_active", {7'd0, out_active}, {7'd0, e_oa});
        chk("R10 indices", {4'd0, lo_idx, hi_idx}, {4'd0, e_li, e_hi_i});
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule